// File: doc/BRIEF.md
# RTC Status Flags and Control Register

This block is the status and control register slice of a real-time clock. It keeps three sticky event flags: data loss, compensation stop and time update. An event sets a flag and the flag stays set until software writes a zero to that bit. Writing a one to a flag does nothing. The data-loss and compensation-stop flags come out of reset already set. This lets software see that the chip has just been powered from cold.

An 8-bit control register answers at two addresses, and both reach the same storage. Its fields are:
- a 2-bit code that selects the temperature compensation interval,
- enables for the update, timer and alarm interrupts,
- a reset-request bit.

The block divides a 2 Hz tick input into a one-cycle compensation strobe at the selected interval. It raises an active-high pull-down enable for an open-drain interrupt pin when the update flag rises while the update interrupt is enabled.

Software reaches the block over a simple synchronous bus: address, write strobe and write data, with read data returned combinationally. The timekeeping counters, the alarm and timer logic and the analog sensing are outside the block. Their events arrive as single-cycle pulses.

Top module: `rtc_flagctl`

## Requirements
- R1: After reset, the status register (address 0x0E) reads 0x03. The control register reads 0x40. Both the interrupt pull-down and the compensation strobe are low.
- R2: A pulse on an event input sets its flag on the next clock edge, and the flag stays set. Status bit positions: bit 0 is data loss, bit 1 is compensation stop, bit 2 is update. Writing a 1 to a flag bit leaves the flag unchanged.
- R3: Writing a 0 to a status flag bit clears that flag. Flags whose bit is written as 1 keep their value. Status bits 7..3 read 0.
- R4: If a clearing write and an event for the same flag fall in the same cycle, the flag ends up set.
- R5: The control register answers at both 0x0F and 0x1F. A write at either address is read back unchanged at the other.
- R6: Control bits 2 and 1 ignore writes and always read 0.
- R7: The compensation strobe fires once every N ticks of the 2 Hz input. The control code in bits 7:6 sets N: 00 gives 1 tick (0.5 s), 01 gives 4 (2 s), 10 gives 20 (10 s) and 11 gives 60 (30 s). The strobe is high for the one cycle after the tick that completes an interval.
- R8: Any control write restarts the interval count, so the first strobe comes N ticks after the write.
- R9: The interrupt pull-down rises together with the update flag when the flag goes from 0 to 1 while the update enable (control bit 5) is 1. It stays low when the enable is 0. Setting the enable while the flag is already 1 does not raise it.
- R10: The interrupt pull-down falls when the update flag is cleared or when the update enable is written to 0.
- R11: Reads of any address other than 0x0E, 0x0F and 0x1F return 0x00.
- R12: The timer enable (control bit 4), alarm enable (bit 3) and reset request (bit 0) appear directly on their output ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| loss_evt | input | 1 | Data-loss event pulse |
| cstop_evt | input | 1 | Compensation-stop event pulse |
| upd_evt | input | 1 | Time-update event pulse |
| tick_2hz | input | 1 | One-cycle pulse at 2 Hz |
| comp_strobe | output | 1 | One-cycle compensation strobe |
| irq_pull | output | 1 | Active-high pull-down enable for the interrupt pin |
| tmr_en | output | 1 | Timer interrupt enable |
| alm_en | output | 1 | Alarm interrupt enable |
| rst_req | output | 1 | Reset request bit |

## Verification
Two functions can fall in the same cycle, and the bench provokes both collisions deliberately.

In the first, a status write that clears the update flag lands in the same cycle as an update event. The bench drives both in one cycle. It expects the flag to read back as 1 while the other flags in that write are cleared.

In the second, a control write lands on the interval counter that the compensation strobe depends on. The bench issues ticks, rewrites the control register part-way through an interval and counts ticks to the next strobe. It expects a full interval rather than the remainder.

// File: rtl/rtc_flagctl_pkg.sv
// Package: shared types for the RTC status/control slice.
// Assumes the control register layout is fixed at 8 bits.
package rtc_flagctl_pkg;

    // Compensation interval select code (control bits 7:6)
    typedef enum logic [1:0] {
        CI_HALF    = 2'b00,
        CI_TWO     = 2'b01,
        CI_TEN     = 2'b10,
        CI_THIRTY  = 2'b11
    } comp_sel_e;

    // Stored (writable) fields of the control register
    typedef struct packed {
        comp_sel_e sel;
        logic      uie;
        logic      tie;
        logic      aie;
        logic      rst;
    } ctrl_t;

    // Status flag indices (bit positions in the status register)
    localparam int unsigned FLG_LOSS  = 0;
    localparam int unsigned FLG_CSTOP = 1;
    localparam int unsigned FLG_UPD   = 2;
    localparam int unsigned NFLAG     = 3;

endpackage

// File: rtl/rtc_sticky_flag.sv
// Module: one sticky status flag.
// Set has priority over clear; clear comes from writing 0 to the bit.
// Assumes set and clr are single-cycle qualified pulses.
module rtc_sticky_flag #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    // Hold the flag: event sets, software zero-write clears, event wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else begin
            q <= set | (q & ~clr);
        end
    end

endmodule

// File: rtl/rtc_comp_timer.sv
// Module: compensation interval divider.
// Counts 2 Hz ticks and emits a one-cycle strobe when the selected
// interval completes. A restart zeroes the count (and wins over a tick).
// Assumes tick is a single-cycle pulse and TICKS_PER_SEC >= 1.
module rtc_comp_timer
    import rtc_flagctl_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      restart,
    input  comp_sel_e sel,
    output logic      strobe
);

    localparam int unsigned HALF_T   = (TICKS_PER_SEC / 2 < 1) ? 1 : TICKS_PER_SEC / 2;
    localparam int unsigned TWO_T    = 2 * TICKS_PER_SEC;
    localparam int unsigned TEN_T    = 10 * TICKS_PER_SEC;
    localparam int unsigned THIRTY_T = 30 * TICKS_PER_SEC;
    localparam int          CNT_W    = $clog2(THIRTY_T + 1);

    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] cnt;

    // Translate the select code into a tick count
    always_comb begin
        case (sel)
            CI_HALF:   period = CNT_W'(HALF_T);
            CI_TWO:    period = CNT_W'(TWO_T);
            CI_TEN:    period = CNT_W'(TEN_T);
            CI_THIRTY: period = CNT_W'(THIRTY_T);
            default:   period = CNT_W'(TWO_T);
        endcase
    end

    // Count ticks, wrap at the period and pulse the strobe on wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            strobe <= 1'b0;
        end else if (restart) begin
            cnt    <= '0;
            strobe <= 1'b0;
        end else if (tick) begin
            if (cnt >= period - 1'b1) begin
                cnt    <= '0;
                strobe <= 1'b1;
            end else begin
                cnt    <= cnt + 1'b1;
                strobe <= 1'b0;
            end
        end else begin
            strobe <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_upd_irq.sv
// Module: update-interrupt pull-down control.
// Raises irq when the update flag goes 0->1 with the enable set (new
// enable value included). Drops it when the flag clears or the enable
// goes to 0. Assumes upd_clr is the zero-write qualifier for the flag.
module rtc_upd_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_evt,
    input  logic upd_clr,
    input  logic upd_q,
    input  logic uie_next,
    output logic irq
);

    logic flag_next;
    logic rise;

    // Predict the flag's next value and whether this edge is a fresh rise
    always_comb begin
        flag_next = upd_evt | (upd_q & ~upd_clr);
        rise      = upd_evt & (~upd_q | upd_clr);
    end

    // Latch the interrupt on a fresh rise; hold while flag and enable stay
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= uie_next & flag_next & (irq | rise);
        end
    end

endmodule

// File: rtl/rtc_flagctl.sv
// Module: RTC status flags and control register (top).
// Status at STAT_ADDR, control aliased at CTRL_ADDR_LO/HI. Read data is
// combinational from bus_addr. Assumes event inputs and tick_2hz are
// single-cycle pulses in the clk domain and one access per cycle.
module rtc_flagctl
    import rtc_flagctl_pkg::*;
#(
    parameter int unsigned           ADDR_W        = 5,
    parameter logic [ADDR_W-1:0]     STAT_ADDR     = 5'h0E,
    parameter logic [ADDR_W-1:0]     CTRL_ADDR_LO  = 5'h0F,
    parameter logic [ADDR_W-1:0]     CTRL_ADDR_HI  = 5'h1F,
    parameter int unsigned           TICKS_PER_SEC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              loss_evt,
    input  logic              cstop_evt,
    input  logic              upd_evt,
    input  logic              tick_2hz,
    output logic              comp_strobe,
    output logic              irq_pull,
    output logic              tmr_en,
    output logic              alm_en,
    output logic              rst_req
);

    localparam logic [NFLAG-1:0] FLAG_RST = 3'b011;
    localparam ctrl_t CTRL_RST = '{sel: CI_TWO, uie: 1'b0, tie: 1'b0,
                                   aie: 1'b0, rst: 1'b0};

    logic             stat_hit;
    logic             ctrl_hit;
    logic             stat_wr;
    logic             ctrl_wr;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_clr;
    logic [NFLAG-1:0] flag_q;
    ctrl_t            ctrl_q;
    logic             uie_next;
    logic             upd_flag;
    logic             uie_q;

    // Decode address hits and write qualifiers
    always_comb begin
        stat_hit = (bus_addr == STAT_ADDR);
        ctrl_hit = (bus_addr == CTRL_ADDR_LO) || (bus_addr == CTRL_ADDR_HI);
        stat_wr  = bus_wr & stat_hit;
        ctrl_wr  = bus_wr & ctrl_hit;
        uie_next = ctrl_wr ? bus_wdata[5] : ctrl_q.uie;
    end

    // Gather event pulses into the flag set vector
    always_comb begin
        flag_set            = '0;
        flag_set[FLG_LOSS]  = loss_evt;
        flag_set[FLG_CSTOP] = cstop_evt;
        flag_set[FLG_UPD]   = upd_evt;
    end

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            assign flag_clr[i] = stat_wr & ~bus_wdata[i];
            rtc_sticky_flag #(
                .RST_VAL (FLAG_RST[i])
            ) u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set   (flag_set[i]),
                .clr   (flag_clr[i]),
                .q     (flag_q[i])
            );
        end
    endgenerate

    // Store the writable control fields; bits 2:1 are never stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else if (ctrl_wr) begin
            ctrl_q.sel <= comp_sel_e'(bus_wdata[7:6]);
            ctrl_q.uie <= bus_wdata[5];
            ctrl_q.tie <= bus_wdata[4];
            ctrl_q.aie <= bus_wdata[3];
            ctrl_q.rst <= bus_wdata[0];
        end
    end

    // Return the addressed register, zero for unmapped addresses
    always_comb begin
        bus_rdata = 8'h00;
        if (stat_hit) begin
            bus_rdata[NFLAG-1:0] = flag_q;
        end else if (ctrl_hit) begin
            bus_rdata = {ctrl_q.sel, ctrl_q.uie, ctrl_q.tie, ctrl_q.aie,
                         2'b00, ctrl_q.rst};
        end
    end

    rtc_comp_timer #(
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) u_comp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_2hz),
        .restart (ctrl_wr),
        .sel     (ctrl_q.sel),
        .strobe  (comp_strobe)
    );

    rtc_upd_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_evt  (upd_evt),
        .upd_clr  (flag_clr[FLG_UPD]),
        .upd_q    (flag_q[FLG_UPD]),
        .uie_next (uie_next),
        .irq      (irq_pull)
    );

    // Bring out control fields consumed by neighbouring blocks
    always_comb begin
        tmr_en   = ctrl_q.tie;
        alm_en   = ctrl_q.aie;
        rst_req  = ctrl_q.rst;
        upd_flag = flag_q[FLG_UPD];
        uie_q    = ctrl_q.uie;
    end

endmodule

// File: rtl/rtc_flagctl_chk.sv
// Checker: temporal properties of rtc_flagctl, attached with bind.
// Assumes the same address parameters as the bound instance.
module rtc_flagctl_chk #(
    parameter int unsigned       ADDR_W       = 5,
    parameter logic [ADDR_W-1:0] STAT_ADDR    = 5'h0E,
    parameter logic [ADDR_W-1:0] CTRL_ADDR_LO = 5'h0F,
    parameter logic [ADDR_W-1:0] CTRL_ADDR_HI = 5'h1F
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              wd_upd,
    input logic              wd_uie,
    input logic [7:0]        bus_rdata,
    input logic              upd_evt,
    input logic              tick_2hz,
    input logic              comp_strobe,
    input logic              irq_pull,
    input logic              upd_flag,
    input logic              uie_q
);

    logic ctrl_sel;
    logic unmapped;
    assign ctrl_sel = (bus_addr == CTRL_ADDR_LO) || (bus_addr == CTRL_ADDR_HI);
    assign unmapped = !ctrl_sel && (bus_addr != STAT_ADDR);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_pull && !comp_strobe));

    // R4
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |=> upd_flag);

    // R3
    zero_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == STAT_ADDR && !wd_upd && !upd_evt) |=> !upd_flag);

    // R6
    protected_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_sel |-> (bus_rdata[2:1] == 2'b00));

    // R7
    strobe_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        comp_strobe |-> $past(tick_2hz));

    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pull |-> (upd_flag && uie_q));

    // R10
    uie_off_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ctrl_sel && !wd_uie) |=> !irq_pull);

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (bus_rdata == 8'h00));

endmodule

bind rtc_flagctl rtc_flagctl_chk #(
    .ADDR_W       (ADDR_W),
    .STAT_ADDR    (STAT_ADDR),
    .CTRL_ADDR_LO (CTRL_ADDR_LO),
    .CTRL_ADDR_HI (CTRL_ADDR_HI)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .wd_upd      (bus_wdata[2]),
    .wd_uie      (bus_wdata[5]),
    .bus_rdata   (bus_rdata),
    .upd_evt     (upd_evt),
    .tick_2hz    (tick_2hz),
    .comp_strobe (comp_strobe),
    .irq_pull    (irq_pull),
    .upd_flag    (upd_flag),
    .uie_q       (uie_q)
);

// File: tb/tb_rtc_flagctl.sv
// Bench: directed scenarios for rtc_flagctl, one task per scenario.
module tb_rtc_flagctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = 5'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       loss_evt = 1'b0;
    logic       cstop_evt = 1'b0;
    logic       upd_evt = 1'b0;
    logic       tick_2hz = 1'b0;
    logic       comp_strobe;
    logic       irq_pull;
    logic       tmr_en;
    logic       alm_en;
    logic       rst_req;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    rtc_flagctl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .loss_evt    (loss_evt),
        .cstop_evt   (cstop_evt),
        .upd_evt     (upd_evt),
        .tick_2hz    (tick_2hz),
        .comp_strobe (comp_strobe),
        .irq_pull    (irq_pull),
        .tmr_en      (tmr_en),
        .alm_en      (alm_en),
        .rst_req     (rst_req)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick_once(output logic s);
        @(negedge clk);
        tick_2hz = 1'b1;
        @(negedge clk);
        tick_2hz = 1'b0;
        s = comp_strobe;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(5'h0E, d); chk("R1", "status after reset", d, 8'h03);
        rd(5'h0F, d); chk("R1", "control after reset", d, 8'h40);
        chk("R1", "irq after reset", irq_pull, 0);
        chk("R1", "strobe after reset", comp_strobe, 0);
    endtask

    task automatic t_sticky();
        logic [7:0] d;
        wr(5'h0E, 8'hFF);
        rd(5'h0E, d); chk("R2", "write ones ignored", d, 8'h03);
        @(negedge clk) upd_evt = 1'b1;
        @(negedge clk) upd_evt = 1'b0;
        repeat (3) @(negedge clk);
        rd(5'h0E, d); chk("R2", "update flag set and held", d, 8'h07);
    endtask

    task automatic t_clear();
        logic [7:0] d;
        wr(5'h0E, 8'hFE);
        rd(5'h0E, d); chk("R3", "clear only loss", d, 8'h06);
        wr(5'h0E, 8'h00);
        rd(5'h0E, d); chk("R3", "clear all", d, 8'h00);
        @(negedge clk) cstop_evt = 1'b1;
        @(negedge clk) cstop_evt = 1'b0;
        rd(5'h0E, d); chk("R2", "cstop flag set", d, 8'h02);
        @(negedge clk) loss_evt = 1'b1;
        @(negedge clk) loss_evt = 1'b0;
        rd(5'h0E, d); chk("R2", "loss flag set", d, 8'h03);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        @(negedge clk);
        bus_addr = 5'h0E; bus_wdata = 8'h00; bus_wr = 1'b1; upd_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; upd_evt = 1'b0;
        rd(5'h0E, d); chk("R4", "event wins over clear", d, 8'h04);
        wr(5'h0E, 8'h00);
        rd(5'h0E, d); chk("R4", "cleared afterwards", d, 8'h00);
    endtask

    task automatic t_alias();
        logic [7:0] d;
        wr(5'h0F, 8'hA1);
        rd(5'h1F, d); chk("R5", "low write seen high", d, 8'hA1);
        wr(5'h1F, 8'h50);
        rd(5'h0F, d); chk("R5", "high write seen low", d, 8'h50);
    endtask

    task automatic t_protect_outputs();
        logic [7:0] d;
        wr(5'h0F, 8'hFF);
        rd(5'h0F, d); chk("R6", "bits 2:1 read zero", d, 8'hF9);
        wr(5'h1F, 8'h19);
        rd(5'h0F, d); chk("R12", "control readback", d, 8'h19);
        chk("R12", "tmr_en", tmr_en, 1);
        chk("R12", "alm_en", alm_en, 1);
        chk("R12", "rst_req", rst_req, 1);
        wr(5'h0F, 8'h40);
        chk("R12", "outputs cleared", {tmr_en, alm_en, rst_req}, 0);
    endtask

    task automatic t_interval(input logic [1:0] code, input int n);
        logic s;
        int errs = 0;
        wr(5'h0F, {code, 6'b0});
        for (int k = 1; k <= 2 * n; k++) begin
            tick_once(s);
            if (s != ((k % n) == 0)) errs++;
        end
        chk("R7", $sformatf("strobe pattern code %0d", code), errs, 0);
    endtask

    task automatic t_restart();
        logic s;
        int first = 0;
        wr(5'h0F, 8'h40);
        tick_once(s); tick_once(s);
        wr(5'h0F, 8'h40);
        for (int k = 1; k <= 6; k++) begin
            tick_once(s);
            if (s && first == 0) first = k;
        end
        chk("R8", "ticks to first strobe after rewrite", first, 4);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        wr(5'h0E, 8'hFB);
        wr(5'h0F, 8'h60);
        chk("R9", "irq idle", irq_pull, 0);
        @(negedge clk) upd_evt = 1'b1;
        @(negedge clk) upd_evt = 1'b0;
        chk("R9", "irq on rise with enable", irq_pull, 1);
        wr(5'h0E, 8'hFB);
        chk("R10", "irq drops on flag clear", irq_pull, 0);
        @(negedge clk) upd_evt = 1'b1;
        @(negedge clk) upd_evt = 1'b0;
        chk("R9", "irq on second rise", irq_pull, 1);
        wr(5'h0F, 8'h40);
        chk("R10", "irq drops on enable off", irq_pull, 0);
        rd(5'h0E, d); chk("R10", "flag still set", d[2], 1);
        wr(5'h0E, 8'hFB);
        @(negedge clk) upd_evt = 1'b1;
        @(negedge clk) upd_evt = 1'b0;
        chk("R9", "no irq with enable off", irq_pull, 0);
        wr(5'h0F, 8'h60);
        chk("R9", "late enable gives no irq", irq_pull, 0);
        wr(5'h0E, 8'hFB);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        rd(5'h00, d); chk("R11", "addr 0x00", d, 0);
        rd(5'h1E, d); chk("R11", "addr 0x1E", d, 0);
        rd(5'h10, d); chk("R11", "addr 0x10", d, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sticky();
        t_clear();
        t_collide();
        t_alias();
        t_protect_outputs();
        t_interval(2'b00, 1);
        t_interval(2'b01, 4);
        t_interval(2'b10, 20);
        t_interval(2'b11, 60);
        t_restart();
        t_irq();
        t_unmapped();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule